// File: doc/BRIEF.md
# Predicated Execution Condition Evaluator

This block decides whether the instruction currently being fetched by a small 16-bit processor is allowed to execute. The top three bits of an instruction's first word hold a predicate field. The field is tested against the carry (C) and zero (Z) flags, and the result is a single execute-enable bit.

The fetch and execute stages overlap, so the predicate and the flags can each come from two places. The predicate is either the word on the incoming data bus or a copy captured from that bus when the first word was fetched. The flags are either the committed status register or the flag values that the instruction now executing will write at the next edge. A 2-bit select, driven by the fetch sequencer, picks one of three predicate/flag pairings:

- a one-word instruction that depends on an already committed result;
- a two-word instruction tested at the end of its operand fetch;
- a one-word instruction that depends on the instruction executing alongside it.

The captured predicate and the status flags are the block's only state. The decision is combinational from them and from the inputs.

Top module: `pred_exec_gate`

## Requirements
- R1: The enable is pinv XOR ((pc OR C) AND (pz OR Z)). The predicate field sits in bits 15:13 of the word: bit 15 is pc, bit 14 is pz and bit 13 is pinv. A control bit at 0 makes the enable depend on its flag.
- R2: Field code 3'b110 (binary, bits 15..13) gives an enable of 1 for every flag value. Code 3'b111 gives 0 for every flag value.
- R3: The flag-dependent codes mean:
  - 3'b100: Z set.
  - 3'b101: Z clear.
  - 3'b010: C set.
  - 3'b011: C clear.
  - 3'b000: both C and Z set.
  - 3'b001: C and Z not both set.
- R4: With src_sel = 0, the predicate comes from data_in[15:13] and the flags come from the committed status. flag_c_nxt and flag_z_nxt have no effect.
- R5: With src_sel = 1, the predicate comes from the captured copy and the flags from the committed status. data_in has no effect.
- R6: With src_sel = 2, the predicate comes from data_in[15:13] and the flags from flag_c_nxt and flag_z_nxt in the same cycle. The committed status has no effect.
- R7: src_sel = 3 behaves exactly as src_sel = 0.
- R8: A clock edge with pred_ld high captures data_in[15:13]. At any other edge the captured predicate holds its value.
- R9: A clock edge with flag_wr high loads flag_c_nxt and flag_z_nxt into the committed status. At any other edge the committed status holds its value.
- R10: A synchronous reset clears both committed flags and sets the captured predicate to code 3'b110.
- R11: exec_en follows its inputs within the same cycle, with no register on the output path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 16 | Incoming data-bus word |
| pred_ld | input | 1 | Capture the bus predicate field at this edge |
| flag_wr | input | 1 | Commit the next-flag values at this edge |
| flag_c_nxt | input | 1 | Carry result of the instruction now executing |
| flag_z_nxt | input | 1 | Zero result of the instruction now executing |
| src_sel | input | 2 | 0 bus/committed, 1 captured/committed, 2 bus/next, 3 as 0 |
| exec_en | output | 1 | Execute enable for the fetched instruction |

## Verification
Two things can fall in the same cycle: the commit of flags and the capture of a predicate, and either of them can coincide with an evaluation that reads the value being replaced. The bench provokes this by raising flag_wr and pred_ld together while the select reads the old committed flags or the next flags. It then switches to the captured/committed pairing on the following cycle. Each such case is judged against a bench model that updates only at the edge. The judgement confirms that the same-cycle decision used the pre-edge state and that the next cycle's decision used both new values.

// File: rtl/pred_pkg.sv
package pred_pkg;

    localparam int WORD_W = 16;
    localparam int PRED_W = 3;
    localparam int PRED_LSB = WORD_W - PRED_W;

    typedef struct packed {
        logic carry_ctl;   // active low: 0 makes the condition use C
        logic zero_ctl;    // active low: 0 makes the condition use Z
        logic invert;
    } pred_t;

    typedef struct packed {
        logic c;
        logic z;
    } flags_t;

    typedef enum logic [1:0] {
        SRC_BUS_COMMIT = 2'd0,
        SRC_IR_COMMIT  = 2'd1,
        SRC_BUS_NEXT   = 2'd2,
        SRC_SPARE      = 2'd3
    } src_sel_e;

    localparam pred_t PRED_ALWAYS = '{carry_ctl: 1'b1, zero_ctl: 1'b1, invert: 1'b0};
    localparam flags_t FLAGS_CLEAR = '{c: 1'b0, z: 1'b0};

    function automatic logic eval_cond(input pred_t p, input flags_t f);
        logic term;
        term = (p.carry_ctl | f.c) & (p.zero_ctl | f.z);
        return p.invert ^ term;
    endfunction

endpackage

// File: rtl/pred_hold_reg.sv
module pred_hold_reg
    import pred_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  pred_t pred_in,
    output pred_t pred_q
);
    always_ff @(posedge clk) begin
        if (rst)
            pred_q <= PRED_ALWAYS;
        else if (load)
            pred_q <= pred_in;
    end
endmodule

// File: rtl/flag_status_reg.sv
module flag_status_reg
    import pred_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr,
    input  flags_t flags_d,
    output flags_t flags_q
);
    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= FLAGS_CLEAR;
        else if (wr)
            flags_q <= flags_d;
    end
endmodule

// File: rtl/cond_select.sv
module cond_select
    import pred_pkg::*;
(
    input  src_sel_e sel,
    input  pred_t    pred_bus,
    input  pred_t    pred_held,
    input  flags_t   flags_committed,
    input  flags_t   flags_next,
    output logic     enable
);
    pred_t  pred_pick;
    flags_t flags_pick;

    always_comb begin
        unique case (sel)
            SRC_IR_COMMIT: begin
                pred_pick  = pred_held;
                flags_pick = flags_committed;
            end
            SRC_BUS_NEXT: begin
                pred_pick  = pred_bus;
                flags_pick = flags_next;
            end
            default: begin
                pred_pick  = pred_bus;
                flags_pick = flags_committed;
            end
        endcase
        enable = eval_cond(pred_pick, flags_pick);
    end
endmodule

// File: rtl/pred_exec_gate.sv
module pred_exec_gate
    import pred_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] data_in,
    input  logic              pred_ld,
    input  logic              flag_wr,
    input  logic              flag_c_nxt,
    input  logic              flag_z_nxt,
    input  logic [1:0]        src_sel,
    output logic              exec_en
);
    pred_t  bus_pred;
    pred_t  held_pred;
    flags_t next_flags;
    flags_t status_flags;
    src_sel_e sel_e;
    logic   unused_low_bits;

    assign bus_pred        = pred_t'(data_in[WORD_W-1:PRED_LSB]);
    assign unused_low_bits = ^data_in[PRED_LSB-1:0];
    assign next_flags      = '{c: flag_c_nxt, z: flag_z_nxt};
    assign sel_e           = src_sel_e'(src_sel);

    pred_hold_reg u_pred (
        .clk     (clk),
        .rst     (rst),
        .load    (pred_ld),
        .pred_in (bus_pred),
        .pred_q  (held_pred)
    );

    flag_status_reg u_flags (
        .clk     (clk),
        .rst     (rst),
        .wr      (flag_wr),
        .flags_d (next_flags),
        .flags_q (status_flags)
    );

    cond_select u_sel (
        .sel             (sel_e),
        .pred_bus        (bus_pred),
        .pred_held       (held_pred),
        .flags_committed (status_flags),
        .flags_next      (next_flags),
        .enable          (exec_en)
    );
endmodule

// File: rtl/pred_exec_chk.sv
module pred_exec_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] data_in,
    input logic        pred_ld,
    input logic        flag_wr,
    input logic        flag_c_nxt,
    input logic        flag_z_nxt,
    input logic [1:0]  src_sel,
    input logic        exec_en
);
    AST_ALWAYS_CODE: assert property (@(posedge clk) disable iff (rst)
        (src_sel != 2'd1 && data_in[15:13] == 3'b110) |-> exec_en); // R2

    AST_NEVER_CODE: assert property (@(posedge clk) disable iff (rst)
        (src_sel != 2'd1 && data_in[15:13] == 3'b111) |-> !exec_en); // R2

    AST_NEXT_FLAG_USE: assert property (@(posedge clk) disable iff (rst)
        (src_sel == 2'd2 && data_in[15:13] == 3'b010) |-> (exec_en == flag_c_nxt)); // R6

    AST_COMMIT_Z: assert property (@(posedge clk) disable iff (rst)
        ($past(flag_wr) && !$past(rst) && src_sel == 2'd0 && data_in[15:13] == 3'b100)
        |-> (exec_en == $past(flag_z_nxt))); // R9

    AST_CAPTURE_NEVER: assert property (@(posedge clk) disable iff (rst)
        ($past(pred_ld) && !$past(rst) && $past(data_in[15:13]) == 3'b111 && src_sel == 2'd1)
        |-> !exec_en); // R8

    AST_RESET_HELD: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && src_sel == 2'd1) |-> exec_en); // R10
endmodule

bind pred_exec_gate pred_exec_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .data_in    (data_in),
    .pred_ld    (pred_ld),
    .flag_wr    (flag_wr),
    .flag_c_nxt (flag_c_nxt),
    .flag_z_nxt (flag_z_nxt),
    .src_sel    (src_sel),
    .exec_en    (exec_en)
);

// File: tb/sim_pred_exec_gate.sv
module sim_pred_exec_gate;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] data_in;
    logic        pred_ld, flag_wr, flag_c_nxt, flag_z_nxt;
    logic [1:0]  src_sel;
    logic        exec_en;

    always #5 clk = ~clk;

    pred_exec_gate u0 (
        .clk(clk), .rst(rst), .data_in(data_in), .pred_ld(pred_ld),
        .flag_wr(flag_wr), .flag_c_nxt(flag_c_nxt), .flag_z_nxt(flag_z_nxt),
        .src_sel(src_sel), .exec_en(exec_en)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic       m_c, m_z;
    logic [2:0] m_pred;

    // R1, R2, R3: meaning of each field code (bit15 pc, bit14 pz, bit13 pinv)
    function automatic logic want(input logic [2:0] code, input logic c, input logic z);
        case (code)
            3'b110:  return 1'b1;
            3'b111:  return 1'b0;
            3'b100:  return z;
            3'b101:  return !z;
            3'b010:  return c;
            3'b011:  return !c;
            3'b000:  return c & z;
            default: return !(c & z);
        endcase
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Drive at negedge, compare mid-cycle (R11), model updates at posedge
    task automatic step(input string req, input logic r, input logic [1:0] s,
                        input logic [15:0] w, input logic ld, input logic wr,
                        input logic cn, input logic zn, input logic do_chk);
        logic exp;
        @(negedge clk);
        rst = r; src_sel = s; data_in = w; pred_ld = ld;
        flag_wr = wr; flag_c_nxt = cn; flag_z_nxt = zn;
        #2;
        case (s)
            2'd1:    exp = want(m_pred, m_c, m_z);
            2'd2:    exp = want(w[15:13], cn, zn);
            default: exp = want(w[15:13], m_c, m_z);
        endcase
        if (do_chk) check(req, exec_en, exp);
        @(posedge clk);
        if (r) begin
            m_c = 1'b0; m_z = 1'b0; m_pred = 3'b110;
        end else begin
            if (ld) m_pred = w[15:13];
            if (wr) begin m_c = cn; m_z = zn; end
        end
    endtask

    function automatic string sel_req(input logic [1:0] s);
        case (s)
            2'd0:    return "R4 R1";
            2'd1:    return "R5 R8 R9";
            2'd2:    return "R6 R3";
            default: return "R7";
        endcase
    endfunction

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        m_c = 1'bx; m_z = 1'bx; m_pred = 3'bxxx;
        step("", 1, 0, 16'h0, 0, 0, 0, 0, 0);
        step("", 1, 0, 16'h0, 0, 0, 0, 0, 0);
        // R10: reset state, bus ignored in captured mode
        step("R10 held", 0, 1, 16'hE000, 0, 0, 1, 1, 1);
        step("R10 zflag", 0, 0, 16'h8000, 0, 0, 1, 1, 1);
        step("R10 cflag", 0, 0, 16'h4000, 0, 0, 1, 1, 1);

        // Mode 0 and 3: all codes against all committed flags, next flags opposite
        for (int s = 0; s < 4; s += 3)
            for (int f = 0; f < 4; f++) begin
                step("R9 load", 0, 2, 16'h0, 0, 1, f[1], f[0], 1);
                for (int code = 0; code < 8; code++)
                    step(sel_req(2'(s)), 0, 2'(s), {3'(code), 13'h1ABC}, 0, 0, !f[1], !f[0], 1);
            end
        // Mode 1: capture then evaluate with inverted bus bits
        for (int f = 0; f < 4; f++) begin
            step("R9 load", 0, 2, 16'h0, 0, 1, f[1], f[0], 1);
            for (int code = 0; code < 8; code++) begin
                step("R8 load", 0, 0, {3'(code), 13'h0}, 1, 0, 0, 0, 1);
                step(sel_req(1), 0, 1, {~3'(code), 13'h0}, 0, 0, 0, 0, 1);
            end
        end
        // Mode 2: all codes against all next flags, committed opposite
        for (int f = 0; f < 4; f++) begin
            step("R9 load", 0, 0, 16'h0, 0, 1, !f[1], !f[0], 1);
            for (int code = 0; code < 8; code++)
                step(sel_req(2), 0, 2, {3'(code), 13'h0F0F}, 0, 0, f[1], f[0], 1);
        end
        // Same-cycle capture and commit, then captured/committed
        step("R6 R8 R9 same", 0, 2, 16'h8000, 1, 1, 0, 1, 1);
        step("R5 after both", 0, 1, 16'hE000, 0, 0, 0, 0, 1);
        step("R4 R9 same", 0, 0, 16'h4000, 1, 1, 1, 0, 1);
        step("R5 after both", 0, 1, 16'hE000, 0, 0, 0, 0, 1);
        // Hold: no load, no write
        step("R8 hold", 0, 1, 16'hE000, 0, 0, 0, 0, 1);
        step("R9 hold", 0, 0, 16'h4000, 0, 0, 0, 1, 1);

        // Constrained random
        for (int i = 0; i < 400; i++) begin
            logic [1:0] s;
            s = 2'($urandom_range(0, 3));
            step(sel_req(s), ($urandom_range(0, 99) == 0), s, 16'($urandom),
                 ($urandom_range(0, 3) == 0), ($urandom_range(0, 2) == 0),
                 1'($urandom), 1'($urandom), 1);
        end
        // Reset mid-run restores defaults
        step("", 1, 0, 16'h0, 0, 0, 0, 0, 0);
        step("R10 again", 0, 1, 16'hE000, 0, 0, 1, 1, 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule